// File: doc/BRIEF.md
# Test Mode Entry Controller

This block sits between the chip core and the pad ring and decides when the device leaves normal operation for a pin-level test mode. An active-low test pin enables it. While that pin is high, three request pins are ordinary address inputs and pass straight through to the core. When the test pin falls, the value on those three pins is latched as a mode code. From then on the pins are ignored until the test pin is released.

The latched mode drives overrides across the whole pad ring. The output and enable buses can be forced to all-low, all-high or all-floating, with pull resistors switched off in the floating case. A quiescent-current mode also raises disable strobes for the sense amplifiers and the PLL. A clock bypass mode swaps an external clock in for the PLL clock. A monitor mode routes the PLL clock and lock flag onto two spare pads. Releasing the test pin restores normal function on the next clock edge, and all overrides clear at once.

Top module: `test_mode_ctrl`

## Requirements
- R1: While `testPinN` is 1, `coreAddr` equals `reqPins` in the same cycle with no clock delay. While `testPinN` is 0, `coreAddr` is 0.
- R2: The mode is captured from `reqPins` at the first rising clock edge at which `testPinN` is sampled 0 after having been sampled 1 at the previous edge. It takes effect right after that edge.
- R3: While `testPinN` stays 0, changes on `reqPins` have no effect on any pad, clock or disable output.
- R4: Mode code 3'b001 (drive-low): every `padOe` bit is 1, every `padOut` bit is 0, and `padPullEn` is 1.
- R5: Mode code 3'b010 (drive-high): every `padOe` bit is 1, every `padOut` bit is 1, and `padPullEn` is 1.
- R6: Mode code 3'b011 (float): every `padOe` bit is 0, every `padOut` bit is 0, and `padPullEn` is 0.
- R7: Mode code 3'b100 (quiescent current): the pads are as in R6, and `senseAmpDis` and `pllDis` are both 1. In every other mode both strobes are 0.
- R8: Mode code 3'b101 (clock bypass): `coreClk` follows `extClk`, and the pads carry `coreOut` and `coreOe`. In every other mode `coreClk` follows `pllClk`.
- R9: Mode code 3'b110 (monitor): pad bit 0 carries `pllClk` and pad bit 1 carries `pllLock`, both with their output enable set. All other pads carry `coreOut` and `coreOe`.
- R10: Mode codes 3'b000 and 3'b111 give normal function. `padOut` equals `coreOut`, `padOe` equals `coreOe`, `padPullEn` is 1, and `coreClk` follows `pllClk`.
- R11: When `testPinN` is sampled 1 at a rising edge, the block is in normal mode (R10) right after that edge, with every override cleared together. Before that edge the previous mode still holds.
- R12: During and after reset with `testPinN` high, the block is in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| testPinN | input | 1 | Active-low test enable pin |
| reqPins | input | 3 | Shared address / mode request pins |
| coreAddr | output | 3 | Address bits forwarded to the core |
| coreOut | input | PAD_W | Core output data per pad |
| coreOe | input | PAD_W | Core output enable per pad |
| pllClk | input | 1 | Clock from the PLL |
| pllLock | input | 1 | PLL lock flag |
| extClk | input | 1 | Externally supplied test clock |
| padOut | output | PAD_W | Data to pad drivers |
| padOe | output | PAD_W | Enable to pad drivers |
| padPullEn | output | 1 | Pull-up/pull-down enable for the pad ring |
| senseAmpDis | output | 1 | Sense amplifier disable |
| pllDis | output | 1 | PLL disable |
| coreClk | output | 1 | Clock delivered to the core |

## Verification
Two events can fall in the same cycle: the release of the test pin and a change on the request pins, which are then ordinary address bits again. The bench releases the pin and changes the request value at the same instant. It judges that the address reaches the core at once, the old mode holds until the edge, and normal mode follows right after that edge. The bench also re-enters test mode one cycle after a release and judges that the new code is captured cleanly, not lost or merged with the old one.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int REQ_W = 3;

  typedef enum logic [REQ_W-1:0] {
    MODE_NORMAL = 3'd0,
    MODE_DRIVE0 = 3'd1,
    MODE_DRIVE1 = 3'd2,
    MODE_FLOAT  = 3'd3,
    MODE_QUIET  = 3'd4,
    MODE_CLKBYP = 3'd5,
    MODE_CLKMON = 3'd6,
    MODE_SPARE  = 3'd7
  } tmMode_e;

  typedef struct packed {
    logic drvLow;
    logic drvHigh;
    logic floatAll;
    logic quiet;
    logic clkBypass;
    logic clkMonitor;
  } tmStrobe_t;
endpackage

// File: rtl/tmc_ctrl.sv
module tmc_ctrl
  import tmc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             testPinN,
  input  logic [REQ_W-1:0] reqPins,
  output tmMode_e          modeQ,
  output tmStrobe_t        strobe
);
  logic testPrevN;
  logic fallSeen;

  assign fallSeen = testPrevN & ~testPinN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      testPrevN <= 1'b1;
      modeQ     <= MODE_NORMAL;
    end else begin
      testPrevN <= testPinN;
      if (testPinN) begin
        modeQ <= MODE_NORMAL;
      end else if (fallSeen) begin
        modeQ <= tmMode_e'(reqPins);
      end
    end
  end

  always_comb begin
    strobe = '0;
    unique case (modeQ)
      MODE_DRIVE0: strobe.drvLow     = 1'b1;
      MODE_DRIVE1: strobe.drvHigh    = 1'b1;
      MODE_FLOAT:  strobe.floatAll   = 1'b1;
      MODE_QUIET:  strobe.quiet      = 1'b1;
      MODE_CLKBYP: strobe.clkBypass  = 1'b1;
      MODE_CLKMON: strobe.clkMonitor = 1'b1;
      default:     strobe            = '0;
    endcase
  end
endmodule

// File: rtl/tmc_padpath.sv
module tmc_padpath
  import tmc_pkg::*;
#(
  parameter int PAD_W        = 8,
  parameter int MON_CLK_BIT  = 0,
  parameter int MON_LOCK_BIT = 1
) (
  input  tmStrobe_t        strobe,
  input  logic [PAD_W-1:0] coreOut,
  input  logic [PAD_W-1:0] coreOe,
  input  logic             pllClk,
  input  logic             pllLock,
  input  logic             extClk,
  output logic [PAD_W-1:0] padOut,
  output logic [PAD_W-1:0] padOe,
  output logic             padPullEn,
  output logic             senseAmpDis,
  output logic             pllDis,
  output logic             coreClk
);
  logic floatNow;

  assign floatNow    = strobe.floatAll | strobe.quiet;
  assign padPullEn   = ~floatNow;
  assign senseAmpDis = strobe.quiet;
  assign pllDis      = strobe.quiet;
  assign coreClk     = strobe.clkBypass ? extClk : pllClk;

  for (genvar i = 0; i < PAD_W; i++) begin : g_pad
    logic monBit;
    logic monVal;
    if (i == MON_CLK_BIT) begin : g_clk
      assign monBit = 1'b1;
      assign monVal = pllClk;
    end else if (i == MON_LOCK_BIT) begin : g_lock
      assign monBit = 1'b1;
      assign monVal = pllLock;
    end else begin : g_none
      assign monBit = 1'b0;
      assign monVal = 1'b0;
    end

    always_comb begin
      if (floatNow) begin
        padOut[i] = 1'b0;
        padOe[i]  = 1'b0;
      end else if (strobe.drvLow) begin
        padOut[i] = 1'b0;
        padOe[i]  = 1'b1;
      end else if (strobe.drvHigh) begin
        padOut[i] = 1'b1;
        padOe[i]  = 1'b1;
      end else if (strobe.clkMonitor && monBit) begin
        padOut[i] = monVal;
        padOe[i]  = 1'b1;
      end else begin
        padOut[i] = coreOut[i];
        padOe[i]  = coreOe[i];
      end
    end
  end
endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl
  import tmc_pkg::*;
#(
  parameter int PAD_W        = 8,
  parameter int MON_CLK_BIT  = 0,
  parameter int MON_LOCK_BIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             testPinN,
  input  logic [2:0]       reqPins,
  output logic [2:0]       coreAddr,
  input  logic [PAD_W-1:0] coreOut,
  input  logic [PAD_W-1:0] coreOe,
  input  logic             pllClk,
  input  logic             pllLock,
  input  logic             extClk,
  output logic [PAD_W-1:0] padOut,
  output logic [PAD_W-1:0] padOe,
  output logic             padPullEn,
  output logic             senseAmpDis,
  output logic             pllDis,
  output logic             coreClk
);
  tmMode_e   modeQ;
  tmStrobe_t strobe;

  assign coreAddr = testPinN ? reqPins : '0;

  tmc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .testPinN (testPinN),
    .reqPins  (reqPins),
    .modeQ    (modeQ),
    .strobe   (strobe)
  );

  tmc_padpath #(
    .PAD_W        (PAD_W),
    .MON_CLK_BIT  (MON_CLK_BIT),
    .MON_LOCK_BIT (MON_LOCK_BIT)
  ) u_pad (
    .strobe      (strobe),
    .coreOut     (coreOut),
    .coreOe      (coreOe),
    .pllClk      (pllClk),
    .pllLock     (pllLock),
    .extClk      (extClk),
    .padOut      (padOut),
    .padOe       (padOe),
    .padPullEn   (padPullEn),
    .senseAmpDis (senseAmpDis),
    .pllDis      (pllDis),
    .coreClk     (coreClk)
  );
endmodule

// File: rtl/tmc_checker.sv
module tmc_checker
  import tmc_pkg::*;
#(
  parameter int PAD_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             testPinN,
  input logic [2:0]       reqPins,
  input logic [PAD_W-1:0] coreOut,
  input logic [PAD_W-1:0] coreOe,
  input logic [PAD_W-1:0] padOut,
  input logic [PAD_W-1:0] padOe,
  input logic             padPullEn,
  input logic             senseAmpDis,
  input logic             pllDis,
  input tmMode_e          modeQ
);
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !testPinN && $past(testPinN)) |=> (modeQ == tmMode_e'($past(reqPins))));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !testPinN && !$past(testPinN)) |=> $stable(modeQ));

  a_r4_drive_low: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DRIVE0) |-> (padOe == '1 && padOut == '0 && padPullEn));

  a_r6_float: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_FLOAT) |-> (padOe == '0 && !padPullEn));

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_QUIET) |-> (senseAmpDis && pllDis && padOe == '0 && !padPullEn));

  a_r11_release: assert property (@(posedge clk) disable iff (!rstN)
    testPinN |=> (padOe == coreOe && padOut == coreOut && padPullEn && !senseAmpDis && !pllDis));
endmodule

bind test_mode_ctrl tmc_checker #(.PAD_W(PAD_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .testPinN    (testPinN),
  .reqPins     (reqPins),
  .coreOut     (coreOut),
  .coreOe      (coreOe),
  .padOut      (padOut),
  .padOe       (padOe),
  .padPullEn   (padPullEn),
  .senseAmpDis (senseAmpDis),
  .pllDis      (pllDis),
  .modeQ       (modeQ)
);

// File: tb/test_mode_ctrl_bench.sv
`timescale 1ns/1ps
module test_mode_ctrl_bench;
  localparam int PAD_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testPinN = 1'b1;
  logic [2:0] reqPins = 3'd0;
  logic [2:0] coreAddr;
  logic [PAD_W-1:0] coreOut = '0, coreOe = '0, padOut, padOe;
  logic pllClk = 1'b0, pllLock = 1'b0, extClk = 1'b0;
  logic padPullEn, senseAmpDis, pllDis, coreClk;

  int applied = 0;
  int failed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  test_mode_ctrl #(.PAD_W(PAD_W)) u_test_mode_ctrl (.*);

  function automatic logic [19:0] model(int m, logic [7:0] co, logic [7:0] oe,
                                        logic pc, logic pl, logic ec);
    logic [7:0] o = co;
    logic [7:0] e = oe;
    logic pull = 1'b1, sa = 1'b0, pd = 1'b0, ck = pc;
    case (m)
      1: begin o = 8'h00; e = 8'hFF; end
      2: begin o = 8'hFF; e = 8'hFF; end
      3: begin o = 8'h00; e = 8'h00; pull = 1'b0; end
      4: begin o = 8'h00; e = 8'h00; pull = 1'b0; sa = 1'b1; pd = 1'b1; end
      5: ck = ec;
      6: begin o[0] = pc; o[1] = pl; e[0] = 1'b1; e[1] = 1'b1; end
      default: ;
    endcase
    return {o, e, pull, sa, pd, ck};
  endfunction

  function automatic string tagOf(int m);
    case (m)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [19:0] observed();
    return {padOut, padOe, padPullEn, senseAmpDis, pllDis, coreClk};
  endfunction

  task automatic check(string req, logic [19:0] act, logic [19:0] exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkPads(string req, int m);
    check(req, observed(), model(m, coreOut, coreOe, pllClk, pllLock, extClk));
  endtask

  task automatic enterMode(int m);
    @(negedge clk);
    reqPins = 3'(m);
    testPinN = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic leaveMode();
    @(negedge clk);
    testPinN = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failed++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    coreOut = 8'hA5; coreOe = 8'h3C;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkPads("R12", 0);
    rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkPads("R12", 0);

    // R1: address pass-through with the test pin high
    for (int a = 0; a < 8; a++) begin
      reqPins = 3'(a);
      #1;
      check("R1", 20'(coreAddr), 20'(a));
    end

    // R2/R4..R10: sweep every mode over data and clock-source patterns
    for (int m = 0; m < 8; m++) begin
      enterMode(m);
      check("R1", 20'(coreAddr), 20'd0);
      for (int p = 0; p < 4; p++) begin
        for (int s = 0; s < 8; s++) begin
          coreOut = 8'h5A ^ 8'(p * 37);
          coreOe  = ~8'(p * 53);
          pllClk  = s[0];
          pllLock = s[1];
          extClk  = s[2];
          #1;
          checkPads(tagOf(m), m);
        end
      end
      leaveMode();
      checkPads("R11", 0);
    end

    // R3: request-pin changes while held in test mode are ignored
    for (int m = 1; m < 7; m++) begin
      enterMode(m);
      for (int g = 0; g < 8; g++) begin
        @(negedge clk);
        reqPins = 3'(g);
        @(posedge clk); @(negedge clk);
        checkPads("R3", m);
      end
      leaveMode();
    end

    // R11/R1: release and request-pin change in the same cycle
    enterMode(2);
    @(negedge clk);
    testPinN = 1'b1;
    reqPins = 3'd6;
    #1;
    check("R1", 20'(coreAddr), 20'd6);
    checkPads("R11", 2);
    @(posedge clk); @(negedge clk);
    checkPads("R11", 0);

    // R2: re-entry one cycle after release picks up the new code
    enterMode(3);
    @(negedge clk);
    testPinN = 1'b1;
    @(posedge clk); @(negedge clk);
    checkPads("R11", 0);
    reqPins = 3'd4;
    testPinN = 1'b0;
    @(posedge clk); @(negedge clk);
    checkPads("R2", 4);
    reqPins = 3'd1;
    @(posedge clk); @(negedge clk);
    checkPads("R2", 4);
    leaveMode();
    checkPads("R11", 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule